// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target with Half-Array Select

This block is a synthesizable stand-in for a serial EEPROM that sits on a two-wire (I2C) bus as a target. The bus lines are oversampled by the system clock. SDA is driven low through an open-drain enable. The byte array is split into two equal halves. One bit of the control byte chooses the half, and the 16-bit word address picks a byte inside that half. The block supports single-byte and page writes, random reads, current-address reads and sequential reads.

Two straps put the device at one of four bus positions. A third strap must be high, or the device stays silent. A write-protect input keeps the array unchanged while still letting write traffic complete normally on the bus. After a write ends, a write cycle of fixed length is modeled, and the host detects its end by acknowledge polling. The half size defaults to 1 KB so that default builds stay small. Setting `BLK_AW` to 16 gives the full 64 KB halves.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the SDA output enable is low and no write cycle is in progress.
- R2: A control byte is acknowledged only when its bits 7..4 are 1010, its bit 2 equals `strap_a1` and its bit 1 equals `strap_a0`. Bit 3 selects the half and bit 0 selects read (1) or write (0). Any other control byte is not acknowledged.
- R3: While `strap_a2` is low, no control byte is acknowledged.
- R4: A write sends the word address as two bytes, high byte first. Only the low `BLK_AW` address bits are used. Every address and data byte is acknowledged, and a single data byte is stored at the addressed location.
- R5: During a write, the address advances only in its low `PAGE_W` bits. Data past the end of a 2^`PAGE_W`-byte page wraps to the start of that same page.
- R6: A random read (write of the word address, repeated START, control byte with read bit) returns the byte stored at that address.
- R7: Reads return data from the half named in the control byte. A current-address read continues from one past the last byte accessed. A sequential read wraps from the last byte of a half to byte 0 of the same half.
- R8: While `wp_i` is high, write address and data bytes are still acknowledged, but the array is not changed and no write cycle starts.
- R9: The write cycle starts at the STOP that ends an unprotected write and lasts `WR_CYC` clocks. During that time every control byte is not acknowledged, and afterwards control bytes are acknowledged again.
- R10: After the host answers a read byte with NACK, the device releases SDA and waits for STOP or START.
- R11: Locations never written read as 8'hFF.
- R12: SDA is taken low only just after a falling SCL edge, and it is released at every STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_a0 | input | 1 | Bus position strap, compared with control bit 1 |
| strap_a1 | input | 1 | Bus position strap, compared with control bit 2 |
| strap_a2 | input | 1 | Enable strap, must be high for any response |
| wp_i | input | 1 | Write protect, high blocks array changes |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
Two functions can fall together in one cycle: the STOP that closes a write arms the write-cycle timer, and the very next control byte is judged for acknowledge while that timer runs. The bench polls with a control byte straight after the STOP. It expects NACK there, and ACK once `WR_CYC` clocks have passed. The same pairing is checked with write protect high, where the data bytes are acknowledged but the immediate poll must be acknowledged because no cycle was started.

// File: rtl/eep_pkg.sv
package eep_pkg;
  // protocol phase of the target
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_RACK
  } eep_st_t;

  // fixed device-type nibble at the top of the control byte
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
// Oversamples SCL/SDA and finds edges and bus conditions.
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_q,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_sr;
  logic [STAGES:0] sda_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[STAGES-1:0], scl_i};
      sda_sr <= {sda_sr[STAGES-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now = scl_sr[STAGES-1];
  assign scl_old = scl_sr[STAGES];
  assign sda_q   = sda_sr[STAGES-1];
  assign sda_old = sda_sr[STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  // data moves while clock stays high
  assign start_det = scl_now & scl_old & sda_old & ~sda_q;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_q;
endmodule

// File: rtl/eep_mem.sv
// Single-port byte array, read-first, inferable as block RAM.
module eep_mem #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] ram [DEPTH];

  // erased state
  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    rdata <= ram[addr];
  end
endmodule

// File: rtl/eep_wr_timer.sv
// Models the internal programming time in clock cycles.
module eep_wr_timer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (go) begin
      cnt  <= CW'(CYCLES - 1);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter int BLK_AW      = 10,     // address bits per half (9..16)
  parameter int PAGE_W      = 7,      // page = 2**PAGE_W bytes
  parameter int WR_CYC      = 500000, // write-cycle length in clocks
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_a0,
  input  logic strap_a1,
  input  logic strap_a2,
  input  logic wp_i,
  output logic sda_oe
);
  localparam int MEM_AW = BLK_AW + 1;
  localparam int HI_W   = BLK_AW - 8;

  logic scl_rise, scl_fall, sda_q, start_det, stop_det;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_q     (sda_q),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  logic wr_go, wr_busy;

  eep_wr_timer #(.CYCLES(WR_CYC)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .go   (wr_go),
    .busy (wr_busy)
  );

  eep_st_t           st;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [7:0]        tx;
  logic              ack_ph;
  logic              blk;
  logic [BLK_AW-1:0] ptr;
  logic [HI_W-1:0]   ahi;
  logic              wr_pend;
  logic              host_ack;

  logic [7:0]        rd_q;
  logic [MEM_AW-1:0] mem_addr;
  logic              byte_done;
  logic              mem_we;
  logic              ctrl_hit;
  logic [BLK_AW-1:0] ptr_page_nxt;
  logic [BLK_AW-1:0] ptr_seq_nxt;

  assign mem_addr  = {blk, ptr};
  assign byte_done = scl_fall && !ack_ph && (bitcnt == 4'd8)
                     && !start_det && !stop_det;
  assign mem_we    = byte_done && (st == ST_WDAT) && !wp_i;

  assign ctrl_hit  = (shreg[7:4] == DEV_TYPE) && (shreg[2] == strap_a1)
                     && (shreg[1] == strap_a0) && strap_a2 && !wr_busy;

  // writes stay in their page, reads stay in their half
  assign ptr_page_nxt = {ptr[BLK_AW-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
  assign ptr_seq_nxt  = ptr + BLK_AW'(1);

  eep_mem #(.AW(MEM_AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (shreg),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      tx       <= '0;
      ack_ph   <= 1'b0;
      blk      <= 1'b0;
      ptr      <= '0;
      ahi      <= '0;
      wr_pend  <= 1'b0;
      host_ack <= 1'b0;
      wr_go    <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      wr_go <= 1'b0;
      if (start_det) begin
        st     <= ST_CTRL;
        bitcnt <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st      <= ST_IDLE;
        ack_ph  <= 1'b0;
        sda_oe  <= 1'b0;
        wr_go   <= wr_pend;
        wr_pend <= 1'b0;
      end else if (ack_ph) begin
        // the ack clock ends on this fall
        if (scl_fall) begin
          ack_ph <= 1'b0;
          if (st == ST_RDAT) begin
            tx     <= rd_q;
            sda_oe <= ~rd_q[7];
            bitcnt <= 4'd1;
            ptr    <= ptr_seq_nxt;
          end else begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
          end
        end
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_CTRL, ST_AHI, ST_ALO, ST_WDAT: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_q};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              unique case (st)
                ST_CTRL: begin
                  if (ctrl_hit) begin
                    blk    <= shreg[3];
                    ack_ph <= 1'b1;
                    sda_oe <= 1'b1;
                    st     <= shreg[0] ? ST_RDAT : ST_AHI;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                ST_AHI: begin
                  ahi    <= shreg[HI_W-1:0];
                  ack_ph <= 1'b1;
                  sda_oe <= 1'b1;
                  st     <= ST_ALO;
                end
                ST_ALO: begin
                  ptr    <= {ahi, shreg};
                  ack_ph <= 1'b1;
                  sda_oe <= 1'b1;
                  st     <= ST_WDAT;
                end
                default: begin
                  if (!wp_i) wr_pend <= 1'b1;
                  ptr    <= ptr_page_nxt;
                  ack_ph <= 1'b1;
                  sda_oe <= 1'b1;
                end
              endcase
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_q;
            end else if (scl_fall) begin
              if (host_ack) begin
                tx     <= rd_q;
                sda_oe <= ~rd_q[7];
                bitcnt <= 4'd1;
                ptr    <= ptr_seq_nxt;
                st     <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
  parameter int AW = 11,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          sda_oe,
  input logic          busy,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          wp_i
);
  logic             have_last;
  logic [AW-PW-1:0] last_pg;

  always_ff @(posedge clk) begin
    if (rst || start_det || stop_det) begin
      have_last <= 1'b0;
      last_pg   <= '0;
    end else if (mem_we) begin
      have_last <= 1'b1;
      last_pg   <= mem_addr[AW-1:PW];
    end
  end

  assert_wp_block_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !wp_i);

  assert_busy_silent_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  assert_cycle_after_stop_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det, 2));

  assert_stop_release_R12: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  assert_drive_on_fall_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));

  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && have_last) |-> (mem_addr[AW-1:PW] == last_pg));
endmodule

bind i2c_eeprom_target eep_chk #(.AW(BLK_AW + 1), .PW(PAGE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sda_oe    (sda_oe),
  .busy      (wr_busy),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .wp_i      (wp_i)
);

// File: tb/tb_i2c_eeprom_target.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_target;
  localparam int BLK_AW = 10;
  localparam int PAGE_W = 7;
  localparam int WR     = 300;
  localparam int Q      = 10;
  localparam logic A0V  = 1'b1;
  localparam logic A1V  = 1'b0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic host_lo = 1'b0;
  logic a2 = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;

  always #2.5 clk = ~clk;

  assign sda_line = ~(host_lo | sda_oe);

  i2c_eeprom_target #(.BLK_AW(BLK_AW), .PAGE_W(PAGE_W), .WR_CYC(WR),
                      .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .strap_a0(A0V), .strap_a1(A1V), .strap_a2(a2), .wp_i(wp),
    .sda_oe(sda_oe));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ctl(input logic b, input logic rw);
    return {4'b1010, b, A1V, A0V, rw};
  endfunction

  task automatic put_bit(input logic b);
    host_lo = ~b; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    host_lo = 1'b0; tick(Q); scl = 1'b1; tick(Q); b = sda_line;
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start;
    host_lo = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    host_lo = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    host_lo = 1'b1; tick(Q); scl = 1'b1; tick(Q); host_lo = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic poll(output logic ack);
    bus_start;
    send_byte(ctl(1'b0, 1'b0), ack);
    bus_stop;
  endtask

  // driver: write n bytes, check every ack
  task automatic wr_bytes(input logic b, input logic [15:0] a, input int n,
                          input logic [7:0] d [4], input string tag);
    logic ack;
    bus_start;
    send_byte(ctl(b, 1'b0), ack);   check(ack, tag, ack, 1);
    send_byte(a[15:8], ack);        check(ack, tag, ack, 1);
    send_byte(a[7:0], ack);         check(ack, tag, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack);
      check(ack, tag, ack, 1);
    end
    bus_stop;
  endtask

  task automatic read_tail(input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      got_q.push_back(d);
    end
    // R10: line released after the host NACK
    check(sda_oe == 1'b0, "R10", sda_oe, 0);
    bus_stop;
  endtask

  // driver: push expectations, then random/sequential read
  task automatic rd_expect(input logic b, input logic [15:0] a, input int n,
                           input logic [7:0] e [4], input string tag);
    logic ack;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(e[i]);
      tag_q.push_back(tag);
    end
    bus_start;
    send_byte(ctl(b, 1'b0), ack);
    send_byte(a[15:8], ack);
    send_byte(a[7:0], ack);
    bus_start;
    send_byte(ctl(b, 1'b1), ack);   check(ack, tag, ack, 1);
    read_tail(n);
  endtask

  task automatic cur_expect(input logic b, input logic [7:0] e, input string tag);
    logic ack;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_start;
    send_byte(ctl(b, 1'b1), ack);   check(ack, tag, ack, 1);
    read_tail(1);
  endtask

  // monitor: compare read bytes against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g;
        g = got_q.pop_front();
        if (exp_q.size() == 0) begin
          check(1'b0, "scoreboard", g, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(g == e, t, g, e);
        end
      end
    end
  end

  initial begin
    tick(150000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    tick(5);
    rst = 1'b0;
    tick(5);
    // R1
    check(sda_oe == 1'b0, "R1", sda_oe, 0);
    poll(ack);
    check(ack, "R1", ack, 1);

    // R4: two-byte write; R9 busy right after STOP
    wr_bytes(1'b0, 16'h0010, 2, '{8'hA5, 8'h5A, 8'h00, 8'h00}, "R4");
    poll(ack);
    check(!ack, "R9", ack, 0);
    tick(WR + 40);
    poll(ack);
    check(ack, "R9", ack, 1);

    // R6 random read, R7 current-address read
    rd_expect(1'b0, 16'h0010, 1, '{8'hA5, 8'h00, 8'h00, 8'h00}, "R6");
    cur_expect(1'b0, 8'h5A, "R7");
    // R4: upper word-address bits ignored
    rd_expect(1'b0, 16'h8010, 1, '{8'hA5, 8'h00, 8'h00, 8'h00}, "R4");
    // R11 erased location
    rd_expect(1'b0, 16'h0200, 1, '{8'hFF, 8'h00, 8'h00, 8'h00}, "R11");

    // R7 halves are independent
    wr_bytes(1'b1, 16'h0010, 1, '{8'h3C, 8'h00, 8'h00, 8'h00}, "R7");
    tick(WR + 40);
    rd_expect(1'b1, 16'h0010, 1, '{8'h3C, 8'h00, 8'h00, 8'h00}, "R7");
    rd_expect(1'b0, 16'h0010, 1, '{8'hA5, 8'h00, 8'h00, 8'h00}, "R7");

    // R5 page wrap
    wr_bytes(1'b0, 16'h007E, 4, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5");
    tick(WR + 40);
    rd_expect(1'b0, 16'h007E, 4, '{8'h11, 8'h22, 8'hFF, 8'hFF}, "R5");
    rd_expect(1'b0, 16'h0000, 2, '{8'h33, 8'h44, 8'h00, 8'h00}, "R5");

    // R7 sequential read wraps inside the half
    wr_bytes(1'b1, 16'h03FF, 1, '{8'h77, 8'h00, 8'h00, 8'h00}, "R7");
    tick(WR + 40);
    wr_bytes(1'b1, 16'h0000, 1, '{8'h66, 8'h00, 8'h00, 8'h00}, "R7");
    tick(WR + 40);
    rd_expect(1'b1, 16'h03FF, 3, '{8'h77, 8'h66, 8'hFF, 8'h00}, "R7");

    // R2 mismatched position and device type
    bus_start;
    send_byte({4'b1010, 1'b0, A1V, ~A0V, 1'b0}, ack);
    check(!ack, "R2", ack, 0);
    bus_stop;
    bus_start;
    send_byte({4'b1011, 1'b0, A1V, A0V, 1'b0}, ack);
    check(!ack, "R2", ack, 0);
    bus_stop;

    // R3 enable strap low
    a2 = 1'b0;
    poll(ack);
    check(!ack, "R3", ack, 0);
    a2 = 1'b1;
    poll(ack);
    check(ack, "R3", ack, 1);

    // R8 write protect: acks, no change, no busy
    wp = 1'b1;
    wr_bytes(1'b0, 16'h0010, 1, '{8'h00, 8'h00, 8'h00, 8'h00}, "R8");
    poll(ack);
    check(ack, "R8", ack, 1);
    wp = 1'b0;
    rd_expect(1'b0, 16'h0010, 1, '{8'hA5, 8'h00, 8'h00, 8'h00}, "R8");

    // R12 released after STOP
    check(sda_oe == 1'b0, "R12", sda_oe, 0);

    tick(20);
    if (exp_q.size() != 0) check(1'b0, "scoreboard", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule